// File: doc/BRIEF.md
# Prescaled Compare Tick Timer

This block is a free-standing tick timer. A counter, 24 bits wide by default, advances once every PSC+1 input clocks and is compared against a programmable compare value. On a match it raises a time-out flag, and that flag drives an interrupt line and a wake request. The same match sends single-cycle pulses to a low-power peripheral and to a DMA engine. Software reaches the block through five word registers on a single-cycle write, combinational-read bus. These registers are control, compare, status, count and trigger enables.

There are three counting modes. One-shot stops on the first match. Periodic restarts from zero after each match. Continuous keeps running and wraps. Enabling or disabling the counter takes effect after a fixed lag, and a status bit reports when it has. Writing the count register starts a counter-clear that a busy bit reports. Writing the compare register while running has effects that depend on the mode. In periodic mode a policy bit picks one of three responses: keep running, fire at once, or restart.

Top module: `tick_timer`

## Requirements
- R1: Word addresses are 0 control, 1 compare, 2 status, 3 count and 4 trigger enables. After reset every register reads 0, and irq, wake, trig_periph and trig_dma are 0.
- R2: The counter ticks once every PSC+1 clocks, with PSC in control bits 7:0. In periodic mode (control bits 28:27 = 01), a match against the compare value (compare bits 23:0) sets the time-out flag and returns the counter to 0. Time-outs therefore repeat every (PSC+1)*compare clocks.
- R3: The enable bit is control bit 30. The active bit (control bit 25, read-only) reads 1 on the second clock after enable is written to 1, and the first tick follows. Clearing the enable bit freezes the count, and setting it again resumes from the frozen value.
- R4: In one-shot mode (00), and in the reserved mode 10, the counter stops at the compare value on the match. In the same clock the enable bit and the active bit clear.
- R5: In continuous mode (11), the counter keeps counting past a match, and the match still sets the time-out flag.
- R6: A compare write resets the counter to 0 in one-shot mode, and in periodic mode when the policy bit (control bit 20) is 0. In continuous mode it leaves the counter untouched.
- R7: In periodic mode with the policy bit set, a compare write behaves by value. A value above the count changes only the compare value. A value equal to the count sets the time-out flag at once. A value below the count resets the counter to 0.
- R8: Any write to the count register sets the count to 0 and reloads the prescaler. The busy bit (count bit 31) reads 1 for two clocks, and counting resumes after that.
- R9: The time-out flag (status bit 0) is cleared only by writing 1 to it, and a new time-out wins over a clear in the same clock. irq equals the flag ANDed with the interrupt enable (control bit 29).
- R10: wake equals irq ANDed with the wake enable (control bit 23). While wake and pwr_down are both high, the wake flag (status bit 1) is set. Writing 1 to status bit 1 clears it.
- R11: With control bit 31 clear, a high dbg_halt freezes the counter. With control bit 31 set, dbg_halt is ignored.
- R12: Each time-out gives a one-clock pulse on trig_periph when trigger bit 1 is set, and a one-clock pulse on trig_dma when trigger bit 4 is set. The pulse comes in the same clock in which the flag rises.
- R13: A control write that changes PSC clears both the prescaler and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwr_down | input | 1 | System is in power-down |
| dbg_halt | input | 1 | Debugger is holding the processor |
| irq | output | 1 | Time-out interrupt |
| wake | output | 1 | Wake request |
| trig_periph | output | 1 | Time-out pulse to the low-power peripheral |
| trig_dma | output | 1 | Time-out pulse to the DMA engine |

## Verification
The freeze check on dbg_halt assumes no bus write lands while the halt is in force. The bench holds the bus idle during halts, except for compare writes whose effect it checks on purpose. The trigger check assumes compare values of at least 2, which the random generator keeps, so that two time-outs never fall in adjacent clocks. The prescaler bound assumes PSC changes only through a control write, which is the only path the block offers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_ONCE   = 2'b00,
        MODE_PERIOD = 2'b01,
        MODE_RSVD   = 2'b10,
        MODE_FREE   = 2'b11
    } tmr_mode_e;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_CMP   = 3'd1,
        A_STAT  = 3'd2,
        A_COUNT = 3'd3,
        A_TRIG  = 3'd4
    } tmr_addr_e;

    localparam int B_IGNHALT = 31;
    localparam int B_RUN     = 30;
    localparam int B_IE      = 29;
    localparam int B_MODE    = 27;
    localparam int B_ACT     = 25;
    localparam int B_WAKE    = 23;
    localparam int B_POLICY  = 20;
    localparam int B_BUSY    = 31;
    localparam int B_TRG_PER = 1;
    localparam int B_TRG_DMA = 4;

endpackage

// File: rtl/tmr_lag.sv
module tmr_lag #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic clr,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = clr ? '0 : d;
        end else begin : g_chain
            always_comb sh_d = clr ? '0 : {sh_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];

    // R4: a hardware clear drops the output on the next clock
    assert_lag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = 1'b0;
        if (clr) begin
            pre_d = '0;
        end else if (run) begin
            if (pre_q == div) begin
                pre_d = '0;
                tick  = 1'b1;
            end else begin
                pre_d = pre_q + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2: the phase counter never passes the divisor
    assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= div);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int PSC_W   = 8,
    parameter int EN_LAG  = 2,
    parameter int RST_LAG = 2,
    parameter int AW      = 3,
    parameter int DW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          pwr_down,
    input  logic          dbg_halt,
    output logic          irq,
    output logic          wake,
    output logic          trig_periph,
    output logic          trig_dma
);
    localparam int RW = $clog2(RST_LAG + 1);

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        tmr_mode_e        mode;
        logic             policy;
        logic             wake_en;
        logic             ie;
        logic             run;
        logic             ign;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] cnt;
        logic             tif;
        logic             twkf;
        logic [RW-1:0]    rst_left;
        logic             tp_en;
        logic             td_en;
        logic             tp;
        logic             td;
    } state_t;

    state_t d, q;

    logic wr_ctrl, wr_cmp, wr_stat, wr_count, wr_trig;
    logic active, halt_eff, hold_bus, run_cnt, tick, hit, stop_once;
    logic psc_chg, cmp_clr, cmp_fire, pre_clr, timeout;
    logic [CNT_W-1:0] cmp_new, cnt_next;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign wr_ctrl  = bus_wr && (bus_addr == AW'(A_CTRL));
    assign wr_cmp   = bus_wr && (bus_addr == AW'(A_CMP));
    assign wr_stat  = bus_wr && (bus_addr == AW'(A_STAT));
    assign wr_count = bus_wr && (bus_addr == AW'(A_COUNT));
    assign wr_trig  = bus_wr && (bus_addr == AW'(A_TRIG));

    assign halt_eff = dbg_halt && !q.ign;
    assign hold_bus = wr_ctrl || wr_cmp || wr_count;
    assign run_cnt  = active && !halt_eff && (q.rst_left == '0) && !hold_bus;
    assign psc_chg  = wr_ctrl && (bus_wdata[PSC_W-1:0] != q.psc);
    assign cmp_new  = bus_wdata[CNT_W-1:0];
    assign cnt_next = q.cnt + CNT_W'(1);
    assign hit      = tick && (cnt_next == q.cmp);
    assign stop_once = hit && ((q.mode == MODE_ONCE) || (q.mode == MODE_RSVD));

    // compare-write policy
    always_comb begin
        cmp_clr  = 1'b0;
        cmp_fire = 1'b0;
        if (wr_cmp) begin
            case (q.mode)
                MODE_FREE: ;
                MODE_PERIOD: begin
                    if (!q.policy)           cmp_clr  = 1'b1;
                    else if (cmp_new < q.cnt) cmp_clr  = 1'b1;
                    else if (cmp_new == q.cnt) cmp_fire = 1'b1;
                end
                default: cmp_clr = 1'b1;
            endcase
        end
    end

    assign pre_clr = psc_chg || wr_count || cmp_clr;
    assign timeout = hit || cmp_fire;

    tmr_lag #(.STAGES(EN_LAG)) u_lag (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (q.run),
        .clr   (stop_once),
        .q     (active)
    );

    tmr_prescale #(.W(PSC_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_cnt),
        .clr   (pre_clr),
        .div   (q.psc),
        .tick  (tick)
    );

    always_comb begin
        d = q;
        if (tick) begin
            if (hit && (q.mode == MODE_PERIOD)) d.cnt = '0;
            else                                d.cnt = cnt_next;
        end
        if (stop_once) d.run = 1'b0;
        if (wr_ctrl) begin
            d.psc     = bus_wdata[PSC_W-1:0];
            d.mode    = tmr_mode_e'(bus_wdata[B_MODE +: 2]);
            d.policy  = bus_wdata[B_POLICY];
            d.wake_en = bus_wdata[B_WAKE];
            d.ie      = bus_wdata[B_IE];
            d.run     = bus_wdata[B_RUN];
            d.ign     = bus_wdata[B_IGNHALT];
        end
        if (pre_clr) d.cnt = '0;
        if (wr_cmp) d.cmp = cmp_new;
        if (wr_count)                d.rst_left = RW'(RST_LAG);
        else if (q.rst_left != '0)   d.rst_left = q.rst_left - RW'(1);
        if (wr_stat && bus_wdata[0]) d.tif = 1'b0;
        if (timeout)                 d.tif = 1'b1;
        if (wr_stat && bus_wdata[1]) d.twkf = 1'b0;
        if (wake && pwr_down)        d.twkf = 1'b1;
        if (wr_trig) begin
            d.tp_en = bus_wdata[B_TRG_PER];
            d.td_en = bus_wdata[B_TRG_DMA];
        end
        d.tp = timeout && q.tp_en;
        d.td = timeout && q.td_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq         = q.tif && q.ie;
    assign wake        = irq && q.wake_en;
    assign trig_periph = q.tp;
    assign trig_dma    = q.td;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(A_CTRL): begin
                bus_rdata[PSC_W-1:0]   = q.psc;
                bus_rdata[B_POLICY]    = q.policy;
                bus_rdata[B_WAKE]      = q.wake_en;
                bus_rdata[B_ACT]       = active;
                bus_rdata[B_MODE +: 2] = q.mode;
                bus_rdata[B_IE]        = q.ie;
                bus_rdata[B_RUN]       = q.run;
                bus_rdata[B_IGNHALT]   = q.ign;
            end
            AW'(A_CMP):   bus_rdata[CNT_W-1:0] = q.cmp;
            AW'(A_STAT):  bus_rdata[1:0] = {q.twkf, q.tif};
            AW'(A_COUNT): begin
                bus_rdata[CNT_W-1:0] = q.cnt;
                bus_rdata[B_BUSY]    = (q.rst_left != '0);
            end
            AW'(A_TRIG): begin
                bus_rdata[B_TRG_PER] = q.tp_en;
                bus_rdata[B_TRG_DMA] = q.td_en;
            end
            default: bus_rdata = '0;
        endcase
    end

    assert_oneshot_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_once |=> (!q.run && !active));

    assert_busy_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rst_left != '0) |-> (q.cnt == '0));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.tif && !(wr_stat && bus_wdata[0])) |=> q.tif);

    assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_eff && !bus_wr) |=> (q.cnt == $past(q.cnt)));

    assert_trig_with_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_periph || trig_dma) |-> q.tif);
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        pwr_down = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        irq, wake, trig_periph, trig_dma;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_down(pwr_down),
        .dbg_halt(dbg_halt), .irq(irq), .wake(wake),
        .trig_periph(trig_periph), .trig_dma(trig_dma)
    );

    localparam int CTRL = 0, CMPR = 1, STAT = 2, COUNT = 3, TRIG = 4;

    function automatic logic [31:0] mk(input int psc, input logic [1:0] md, input bit run,
                                       input bit ie = 0, input bit wk = 0,
                                       input bit pol = 0, input bit ign = 0);
        logic [31:0] v = '0;
        v[7:0] = psc[7:0]; v[28:27] = md; v[30] = run; v[29] = ie;
        v[23] = wk; v[20] = pol; v[31] = ign;
        return v;
    endfunction

    function automatic int period_of(input int psc, input int cmpv);
        return (psc + 1) * cmpv;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        bus_addr = 3'(a); bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        bus_addr = 3'(a);
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input bit dma, output int per, output logic [31:0] cnt_at);
        int n = 0;
        while (((dma ? trig_dma : trig_periph) == 1'b0) && n < 3000) begin @(negedge clk); n++; end
        rd(COUNT, cnt_at);
        @(negedge clk);
        n = 1;
        while (((dma ? trig_dma : trig_periph) == 1'b0) && n < 3000) begin @(negedge clk); n++; end
        per = n;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, held, c;
        int per, ps, cv;
        void'($urandom(32'd4242));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(a, v);
            chk(v == 0, "R1 reset register", v, 0);
        end
        chk({irq, wake, trig_periph, trig_dma} == 4'b0, "R1 reset outputs",
            {irq, wake, trig_periph, trig_dma}, 0);

        // R3 enable lag, suspend and resume
        wr(CMPR, 50);
        wr(CTRL, mk(0, 2'b01, 1));
        rd(CTRL, v); chk(v[25] == 0, "R3 active after 0 clocks", v[25], 0);
        idle(1); rd(CTRL, v); chk(v[25] == 0, "R3 active after 1 clock", v[25], 0);
        idle(1); rd(CTRL, v); chk(v[25] == 1, "R3 active after 2 clocks", v[25], 1);
        rd(COUNT, v); chk(v[23:0] == 0, "R3 no tick before active", v[23:0], 0);
        idle(1); rd(COUNT, v); chk(v[23:0] == 1, "R3 first tick", v[23:0], 1);
        wr(CTRL, mk(0, 2'b01, 0));
        idle(3); rd(COUNT, held);
        idle(10); rd(COUNT, v); chk(v == held, "R3 suspended count frozen", v, held);
        wr(CTRL, mk(0, 2'b01, 1));
        idle(3); rd(COUNT, v); chk(v[23:0] == held[23:0] + 1, "R3 resume from held", v, held + 1);

        // R8 count write and busy bit
        wr(COUNT, 32'h55);
        rd(COUNT, v); chk(v == 32'h8000_0000, "R8 busy clock 1", v, 32'h8000_0000);
        idle(1); rd(COUNT, v); chk(v == 32'h8000_0000, "R8 busy clock 2", v, 32'h8000_0000);
        idle(1); rd(COUNT, v); chk(v == 0, "R8 busy cleared", v, 0);
        idle(1); rd(COUNT, v); chk(v == 1, "R8 counting resumes", v, 1);

        // R2 / R12 periodic timing, directed then random
        wr(TRIG, 32'h2);
        wr(CTRL, mk(2, 2'b01, 1));
        wr(CMPR, 5);
        measure(0, per, v);
        chk(v[23:0] == 0, "R2 counter back to 0 at match", v, 0);
        chk(per == period_of(2, 5), "R2 periodic period", per, period_of(2, 5));
        chk(trig_dma == 0, "R12 dma trigger off", trig_dma, 0);
        for (int i = 0; i < 6; i++) begin
            ps = $urandom % 4;
            cv = 2 + ($urandom % 19);
            wr(CTRL, mk(ps, 2'b01, 1));
            wr(CMPR, cv);
            measure(0, per, v);
            chk(per == period_of(ps, cv), "R2 random period", per, period_of(ps, cv));
            chk(v[23:0] == 0, "R2 random wrap to 0", v, 0);
        end
        wr(TRIG, 0);

        // R4 one-shot and reserved mode
        wr(STAT, 3);
        wr(CTRL, mk(0, 2'b00, 1));
        wr(CMPR, 4);
        idle(12);
        rd(COUNT, v); chk(v == 4, "R4 one-shot stops at compare", v, 4);
        rd(CTRL, v); chk(v[30] == 0 && v[25] == 0, "R4 enable and active cleared", v[30:25], 0);
        rd(STAT, v); chk(v[0] == 1, "R4 flag set", v[0], 1);
        idle(5); rd(COUNT, v); chk(v == 4, "R4 stays stopped", v, 4);
        wr(STAT, 3);
        wr(CTRL, mk(0, 2'b10, 1));
        wr(CMPR, 3);
        idle(12);
        rd(COUNT, v); chk(v == 3, "R4 reserved mode stops", v, 3);
        rd(CTRL, v); chk(v[30] == 0, "R4 reserved mode clears enable", v[30], 0);

        // R5 continuous, R6 compare write keeps count
        wr(STAT, 3);
        wr(CTRL, mk(0, 2'b11, 1));
        wr(COUNT, 0);
        idle(12);
        rd(COUNT, v); chk(v[23:0] > 3, "R5 counts past compare", v, 4);
        rd(STAT, c); chk(c[0] == 1, "R5 match flag", c[0], 1);
        rd(COUNT, c);
        wr(CMPR, 1000);
        rd(COUNT, v); chk(v == c, "R6 continuous compare write keeps count", v, c);

        // R6 periodic, policy clear
        wr(CTRL, mk(0, 2'b01, 1));
        idle(5);
        wr(CMPR, 100);
        rd(COUNT, v); chk(v == 0, "R6 periodic compare write restarts", v, 0);

        // R7 policy and R11 halt
        wr(CTRL, mk(0, 2'b01, 1, 0, 0, 1));
        idle(8);
        dbg_halt = 1'b1;
        idle(1); rd(COUNT, c);
        idle(5); rd(COUNT, v); chk(v == c, "R11 halt freezes", v, c);
        wr(STAT, 3);
        wr(CMPR, c + 50);
        rd(COUNT, v); chk(v == c, "R7 larger compare keeps count", v, c);
        rd(STAT, v); chk(v[0] == 0, "R7 larger compare no flag", v[0], 0);
        wr(CMPR, c);
        rd(STAT, v); chk(v[0] == 1, "R7 equal compare fires", v[0], 1);
        rd(COUNT, v); chk(v == c, "R7 equal compare keeps count", v, c);
        wr(STAT, 1);
        wr(CMPR, c - 1);
        rd(COUNT, v); chk(v == 0, "R7 smaller compare restarts", v, 0);
        wr(CTRL, mk(0, 2'b01, 1, 0, 0, 1, 1));
        idle(4);
        rd(COUNT, v); chk(v != 0, "R11 halt ignored when bit 31 set", v, 1);
        dbg_halt = 1'b0;

        // R9 / R10 flags, irq and wake
        wr(STAT, 3);
        wr(CTRL, mk(0, 2'b01, 1, 1, 1));
        wr(CMPR, 6);
        idle(10);
        chk(irq == 1, "R9 irq with flag and enable", irq, 1);
        chk(wake == 1, "R10 wake with enables", wake, 1);
        rd(STAT, v); chk(v[1] == 0, "R10 no wake flag without power-down", v[1], 0);
        wr(STAT, 0);
        rd(STAT, v); chk(v[0] == 1, "R9 writing 0 keeps flag", v[0], 1);
        pwr_down = 1'b1;
        idle(2);
        rd(STAT, v); chk(v[1] == 1, "R10 wake flag in power-down", v[1], 1);
        pwr_down = 1'b0;
        wr(STAT, 2);
        rd(STAT, v); chk(v == 1, "R10 wake flag cleared by 1", v, 1);
        wr(CTRL, mk(0, 2'b01, 0, 1, 0));
        chk(wake == 0 && irq == 1, "R10 wake off with enable clear", {wake, irq}, 1);
        idle(4);
        wr(STAT, 1);
        chk(irq == 0, "R9 irq drops after clear", irq, 0);

        // R13 PSC change resets counter
        wr(CTRL, mk(0, 2'b01, 1));
        wr(CMPR, 200);
        idle(10);
        wr(CTRL, mk(3, 2'b01, 1));
        rd(COUNT, v); chk(v == 0, "R13 PSC change clears counter", v, 0);
        idle(8);
        rd(COUNT, v); chk(v == 2, "R13 divided ticks", v, 2);

        // R12 DMA trigger
        wr(TRIG, 32'h10);
        wr(CTRL, mk(0, 2'b01, 1));
        wr(CMPR, 4);
        measure(1, per, v);
        chk(per == 4, "R12 dma trigger period", per, 4);
        chk(trig_periph == 0, "R12 peripheral trigger off", trig_periph, 0);

        summary();
        $finish;
    end
endmodule